// File: doc/BRIEF.md
# Age-Counter Replacement Tracker

This block keeps the recency order of the ways in every set of a set-associative cache and names the way to evict when a new block must be brought in. Each way of each set owns a small age counter. Age 0 marks the most recently used way, and the highest age, one less than the number of ways, marks the least recently used way. The counters of one set always hold a permutation of 0 to W-1.

The cache controller reports every hit on the update channel, giving the set, the way and a strobe. It reports every refill the same way, with the fill qualifier also raised. A fill counts as a use of the filled way and also marks that way as holding a block. On a separate lookup port the controller presents a set index. It then receives, in the same cycle, the way to replace and a flag that says whether that way is an empty slot or an evicted block. An empty way is always preferred over the age order.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset, way w of every set has age w and every way is empty. A lookup of any set therefore returns victim way 0 with the free flag at 1.
- R2: On an update of (set, way), that way's age becomes 0 at the next clock edge.
- R3: On the same update, every other way of the set whose age is below the touched way's old age has its age raised by exactly one.
- R4: On the same update, every other way of the set whose age is equal to or above the touched way's old age keeps its age.
- R5: When the looked-up set has at least one empty way, the free flag is 1 and the victim is the empty way with the lowest index.
- R6: When every way of the looked-up set holds a block, the free flag is 0 and the victim is the way whose age equals W-1.
- R7: An update with the fill qualifier at 1 marks the way as holding a block. An update with the qualifier at 0 leaves the way's empty or full state unchanged.
- R8: The lookup outputs follow the lookup set index combinationally. An update changes only the set it names, and its effect is visible from the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_vld | input | 1 | Update strobe: the named way was used this cycle |
| touch_fill | input | 1 | Qualifies the update as a refill, which marks the way full |
| touch_set | input | SET_W | Set of the update |
| touch_way | input | WAY_W | Way of the update |
| look_set | input | SET_W | Set whose victim is requested |
| victim_way | output | WAY_W | Way to replace in look_set |
| free_avail | output | 1 | 1 when victim_way is an empty way |

## Verification
The ages can only be seen through victim_way. A wrong increment, a missed clear or an update applied to the wrong set shows up first as a wrong victim for that set, once all of its ways are full. Depending on how far the broken age sits from the top of the order, this takes one to W-1 further updates. A stuck or misplaced full bit shows up at once in free_avail or in the choice of the lowest empty way. For this reason the reference model is compared on every cycle while the lookup index moves across all sets.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
   // index width for a count of n items, never below one bit
   function automatic int idx_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction
endpackage

// File: rtl/lru_age_update.sv
module lru_age_update #(
   parameter int NUM_WAYS = 4,
   parameter int WAY_W    = 2
) (
   input  logic [NUM_WAYS-1:0][WAY_W-1:0] ages_in,
   input  logic [WAY_W-1:0]               way_sel,
   output logic [NUM_WAYS-1:0][WAY_W-1:0] ages_out
);
   logic [WAY_W-1:0] sel_age;
   assign sel_age = ages_in[way_sel];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      always_comb begin
         if (way_sel == WAY_W'(w))
            ages_out[w] = '0;
         else if (ages_in[w] < sel_age)
            ages_out[w] = ages_in[w] + WAY_W'(1);
         else
            ages_out[w] = ages_in[w];
      end
   end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
   parameter int NUM_WAYS = 4,
   parameter int WAY_W    = 2
) (
   input  logic [NUM_WAYS-1:0][WAY_W-1:0] ages,
   input  logic [NUM_WAYS-1:0]            full,
   output logic [WAY_W-1:0]               victim,
   output logic                           free
);
   logic [WAY_W-1:0] empty_way;
   logic [WAY_W-1:0] oldest_way;

   always_comb begin
      free      = 1'b0;
      empty_way = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (!full[w]) begin
            free      = 1'b1;
            empty_way = WAY_W'(w);
         end
      end
   end

   if (NUM_WAYS == 2) begin : g_two
      // ages are {0,1}: way 1 is the oldest exactly when its age is 1
      assign oldest_way = ages[1][0];
   end else begin : g_many
      always_comb begin
         oldest_way = '0;
         for (int w = 0; w < NUM_WAYS; w++)
            if (ages[w] == WAY_W'(NUM_WAYS - 1)) oldest_way = WAY_W'(w);
      end
   end

   assign victim = free ? empty_way : oldest_way;
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker #(
   parameter int NUM_SETS = 128,
   parameter int NUM_WAYS = 4,
   localparam int SET_W   = lru_age_pkg::idx_bits(NUM_SETS),
   localparam int WAY_W   = lru_age_pkg::idx_bits(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_vld,
   input  logic             touch_fill,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [SET_W-1:0] look_set,
   output logic [WAY_W-1:0] victim_way,
   output logic             free_avail
);
   if (NUM_WAYS < 2) begin : g_bad_ways
      $error("lru_age_tracker: NUM_WAYS must be at least 2");
   end
   if (NUM_SETS < 1) begin : g_bad_sets
      $error("lru_age_tracker: NUM_SETS must be at least 1");
   end

   typedef logic [NUM_WAYS-1:0][WAY_W-1:0] age_row_t;

   age_row_t            age_rows  [NUM_SETS];
   logic [NUM_WAYS-1:0] full_rows [NUM_SETS];
   age_row_t            cur_ages;
   age_row_t            next_ages;

   assign cur_ages = age_rows[touch_set];

   lru_age_update #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_update (
      .ages_in  (cur_ages),
      .way_sel  (touch_way),
      .ages_out (next_ages)
   );

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      age_row_t            row_age;
      logic [NUM_WAYS-1:0] row_full;
      logic                hit_here;
      assign hit_here = touch_vld && (touch_set == SET_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int w = 0; w < NUM_WAYS; w++) row_age[w] <= WAY_W'(w);
            row_full <= '0;
         end else if (hit_here) begin
            row_age <= next_ages;
            if (touch_fill) row_full[touch_way] <= 1'b1;
         end
      end

      assign age_rows[s]  = row_age;
      assign full_rows[s] = row_full;
   end

   lru_victim_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
      .ages   (age_rows[look_set]),
      .full   (full_rows[look_set]),
      .victim (victim_way),
      .free   (free_avail)
   );

   // ---------------- assertions ----------------
   logic [SET_W-1:0] chk_set_q;
   logic [WAY_W-1:0] chk_way_q;
   always_ff @(posedge clk) begin
      if (touch_vld) begin
         chk_set_q <= touch_set;
         chk_way_q <= touch_way;
      end
   end

   AST_TOUCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      touch_vld |=> age_rows[chk_set_q][chk_way_q] == '0); // R2

   AST_FILL_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_vld && touch_fill) |=> full_rows[chk_set_q][chk_way_q]); // R7

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk
      AST_YOUNGER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (touch_vld && touch_way != WAY_W'(w) && cur_ages[w] < cur_ages[touch_way])
         |=> age_rows[chk_set_q][w] == WAY_W'($past(cur_ages[w]) + 1)); // R3
      AST_OLDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (touch_vld && touch_way != WAY_W'(w) && cur_ages[w] >= cur_ages[touch_way])
         |=> age_rows[chk_set_q][w] == $past(cur_ages[w])); // R4
   end

   AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      free_avail |-> !full_rows[look_set][victim_way]); // R5

   AST_OLDEST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !free_avail |-> age_rows[look_set][victim_way] == WAY_W'(NUM_WAYS - 1)); // R6
endmodule

// File: tb/sim_lru_age_tracker.sv
module sim_lru_age_tracker;
   localparam int NS = 8;
   localparam int NW = 4;
   localparam int SW = 3;
   localparam int WW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          touch_vld = 1'b0;
   logic          touch_fill = 1'b0;
   logic [SW-1:0] touch_set = '0;
   logic [WW-1:0] touch_way = '0;
   logic [SW-1:0] look_set = '0;
   logic [WW-1:0] victim_way;
   logic          free_avail;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model: per set, ways ordered most recent first; position == age
   int order [NS][$];
   bit full_m [NS][NW];

   always #10 clk = ~clk;

   lru_age_tracker #(.NUM_SETS(NS), .NUM_WAYS(NW)) u0 (
      .clk, .rst_n, .touch_vld, .touch_fill, .touch_set, .touch_way,
      .look_set, .victim_way, .free_avail
   );

   task automatic model_reset();
      for (int s = 0; s < NS; s++) begin
         order[s].delete();
         for (int w = 0; w < NW; w++) begin
            order[s].push_back(w);
            full_m[s][w] = 1'b0;
         end
      end
   endtask

   task automatic expect_out(input int s, output int vic, output bit fr);
      fr = 1'b0;
      vic = order[s][NW-1];
      for (int w = NW - 1; w >= 0; w--)
         if (!full_m[s][w]) begin fr = 1'b1; vic = w; end
   endtask

   task automatic step(input bit tv, input bit tf, input int ts, input int tw,
                       input int ls, input string tag);
      int    ev;
      bit    ef;
      string t;
      @(negedge clk);
      touch_vld  = tv;
      touch_fill = tf;
      touch_set  = SW'(ts);
      touch_way  = WW'(tw);
      look_set   = SW'(ls);
      #2;
      expect_out(ls, ev, ef);
      if (tag.len() != 0) t = tag; else t = ef ? "R5" : "R6";
      n_cmp++;
      if (free_avail !== ef) begin
         n_bad++;
         $display("FAIL %s set %0d free_avail: actual %0b expected %0b", t, ls, free_avail, ef);
      end
      n_cmp++;
      if (victim_way !== WW'(ev)) begin
         n_bad++;
         $display("FAIL %s set %0d victim_way: actual %0d expected %0d", t, ls, victim_way, ev);
      end
      @(posedge clk);
      #1;
      if (tv) begin
         for (int i = 0; i < NW; i++)
            if (order[ts][i] == tw) begin order[ts].delete(i); break; end
         order[ts].push_front(tw);
         if (tf) full_m[ts][tw] = 1'b1;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state on every set
      for (int s = 0; s < NS; s++) step(0, 0, 0, 0, s, "R1");
      // R7, R5: fill set 2 one way at a time, lowest empty way offered
      for (int w = 0; w < NW; w++) begin
         step(1, 1, 2, w, 2, "R5");
         step(0, 0, 0, 0, 2, "R7");
      end
      // R6 with R2/R3/R4: hit middle, youngest-old, then oldest way
      step(1, 0, 2, 2, 2, "R6");
      step(1, 0, 2, 0, 2, "R3");
      step(0, 0, 0, 0, 2, "R4");
      step(1, 0, 2, 1, 2, "R2");
      step(0, 0, 0, 0, 2, "R6");
      // R7: plain access to empty way keeps it empty; R8: other set untouched
      step(1, 0, 5, 0, 2, "R8");
      step(0, 0, 0, 0, 5, "R7");
      step(1, 0, 5, 3, 5, "R8");
      step(0, 0, 0, 0, 5, "R7");
      // long mixed traffic across all sets
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 10) < 7, ($urandom % 4) == 0,
              $urandom % NS, $urandom % NW, $urandom % NS, "");
      end
      // mid-run reset brings back the R1 state
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
      for (int s = 0; s < NS; s++) step(0, 0, 0, 0, s, "R1");
      finish_run();
   end
endmodule